// File: doc/BRIEF.md
# Multi-destination interrupt router

This block gathers up to 86 active-high level interrupt sources into 32-bit banks and routes them to nine destination interrupt lines. Each source has a sticky pending flag and an enable flag. Each destination has its own routing mask in every bank. The flags are captured on every clock. A destination line is raised while at least one source is pending, enabled and routed to it.

Software reaches the block through a plain 32-bit word-addressed register port. The port decodes byte addresses and does one write per cycle, when `req_i` and `we_i` are both high. Read data is combinational from `addr_i` and does not depend on `req_i`.

Enable flags can be written whole. They can also be changed bit by bit, with no read-modify-write, through a set alias and a clear alias. Pending flags are acknowledged by writing ones. For every destination, a read-only identity word per bank tells the handler which sources are asserting that line.

Top module: `irq_route_ctrl`

## Requirements
- R1: Reset (`rst_ni` low, asynchronous) clears every pending, enable and routing bit. While it is low, every register reads zero and `dst_o` is zero.
- R2: A pending bit becomes 1 at every clock edge where its source is high. It stays 1 after the source falls. Bank b holds sources 32*b..32*b+31, with bit i equal to source 32*b+i. If an acknowledge write and a high source hit the same bit in the same cycle, the bit ends up set.
- R3: The pending words are at 0x30, 0x34 and 0x38 (bank 0, 1, 2). A write clears each pending bit whose data bit is 1 and leaves the bits whose data bit is 0.
- R4: The enable words are at 0x48, 0x4C and 0x50. A write replaces the enable bits of that bank, and a read returns them.
- R5: The clear aliases are at 0x54, 0x58 and 0x5C. A 1 in the write data clears that enable bit and a 0 leaves it unchanged. Writing all ones disables the whole bank. A read of an alias returns the bank's enable bits.
- R6: The set aliases are at 0x60, 0x64 and 0x68. A 1 in the write data sets that enable bit and a 0 leaves it unchanged. A read of an alias returns the bank's enable bits.
- R7: The routing word for bank b and destination d is at 0x78 + 4*(9*b + d), with d from 0 to 8. It is read/write. A 1 routes that source to destination d.
- R8: The identity word for bank b and destination d is at 0xE4 + 4*(9*b + d). It reads as pending AND enable AND routing for that bank and destination. Writes to it change nothing.
- R9: `dst_o[d]` is high, in the same cycle, exactly when some identity word of destination d, in any bank, is nonzero.
- R10: Bits 22 to 31 of bank 2 read as zero in every register, ignore writes, and never give an identity bit.
- R11: Any address not listed above reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 86 | Level interrupt sources, active high |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | 10 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| dst_o | output | 9 | Destination interrupt lines, active high |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands in the same cycle as a high source on the same bit. The source has to rise and fall around exactly one clock edge, and the write has to be presented on that same edge. The bench drives the source and the clearing write on the same falling edge and drops the source on the next falling edge. A design that lets the clear win then reads back zero instead of one.

Reaching a destination line takes three independent conditions to line up: a captured pending bit, its enable, and a routing bit. The bench builds these up one at a time, sets up the top bank's highest source as well, and then takes each condition away again to watch the line fall.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned PEND_BASE  = 'h30;
  localparam int unsigned EN_BASE    = 'h48;
  localparam int unsigned EN_CLR_BASE = 'h54;
  localparam int unsigned EN_SET_BASE = 'h60;
  localparam int unsigned ROUTE_BASE = 'h78;

  function automatic int unsigned pend_addr(int unsigned b);
    return PEND_BASE + 4 * b;
  endfunction

  function automatic int unsigned en_addr(int unsigned b);
    return EN_BASE + 4 * b;
  endfunction

  function automatic int unsigned en_clr_addr(int unsigned b);
    return EN_CLR_BASE + 4 * b;
  endfunction

  function automatic int unsigned en_set_addr(int unsigned b);
    return EN_SET_BASE + 4 * b;
  endfunction

  function automatic int unsigned route_addr(int unsigned n_dst, int unsigned b, int unsigned d);
    return ROUTE_BASE + 4 * (n_dst * b + d);
  endfunction

  // identity block sits right after all routing words
  function automatic int unsigned ident_addr(int unsigned n_dst, int unsigned n_bank,
                                             int unsigned b, int unsigned d);
    return ROUTE_BASE + 4 * n_dst * n_bank + 4 * (n_dst * b + d);
  endfunction

  function automatic logic [WORD_W-1:0] bank_mask(int unsigned n_src, int unsigned b);
    logic [WORD_W-1:0] m;
    for (int unsigned i = 0; i < WORD_W; i++) m[i] = ((WORD_W * b + i) < n_src);
    return m;
  endfunction
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int unsigned N_BANK = 3,
  parameter int unsigned N_DST  = 9,
  parameter int unsigned ADDR_W = 10
) (
  input  logic [ADDR_W-1:0]            addr_i,
  output logic [N_BANK-1:0]            pend_hit_o,
  output logic [N_BANK-1:0]            en_hit_o,
  output logic [N_BANK-1:0]            en_clr_hit_o,
  output logic [N_BANK-1:0]            en_set_hit_o,
  output logic [N_BANK-1:0][N_DST-1:0] route_hit_o,
  output logic [N_BANK-1:0][N_DST-1:0] ident_hit_o
);
  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    assign pend_hit_o[b]   = (addr_i == ADDR_W'(pend_addr(b)));
    assign en_hit_o[b]     = (addr_i == ADDR_W'(en_addr(b)));
    assign en_clr_hit_o[b] = (addr_i == ADDR_W'(en_clr_addr(b)));
    assign en_set_hit_o[b] = (addr_i == ADDR_W'(en_set_addr(b)));
    for (genvar d = 0; d < N_DST; d++) begin : g_dst
      assign route_hit_o[b][d] = (addr_i == ADDR_W'(route_addr(N_DST, b, d)));
      assign ident_hit_o[b][d] = (addr_i == ADDR_W'(ident_addr(N_DST, N_BANK, b, d)));
    end
  end
endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank
  import irq_route_pkg::*;
#(
  parameter int unsigned N_DST = 9,
  parameter logic [WORD_W-1:0] VALID = '1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [WORD_W-1:0]              src_i,
  input  logic [WORD_W-1:0]              wdata_i,
  input  logic                           pend_we_i,
  input  logic                           en_we_i,
  input  logic                           en_clr_i,
  input  logic                           en_set_i,
  input  logic [N_DST-1:0]               route_we_i,
  output logic [WORD_W-1:0]              pend_o,
  output logic [WORD_W-1:0]              en_o,
  output logic [N_DST-1:0][WORD_W-1:0]   route_o,
  output logic [N_DST-1:0][WORD_W-1:0]   ident_o
);
  logic [WORD_W-1:0]            src_m, wdata_m;
  logic [WORD_W-1:0]            pend_q, en_q;
  logic [N_DST-1:0][WORD_W-1:0] route_q;

  assign src_m   = src_i & VALID;
  assign wdata_m = wdata_i & VALID;

  // source capture wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else if (pend_we_i) pend_q <= (pend_q & ~wdata_m) | src_m;
    else pend_q <= pend_q | src_m;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (en_we_i) en_q <= wdata_m;
    else if (en_clr_i) en_q <= en_q & ~wdata_m;
    else if (en_set_i) en_q <= en_q | wdata_m;
  end

  for (genvar d = 0; d < N_DST; d++) begin : g_route
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) route_q[d] <= '0;
      else if (route_we_i[d]) route_q[d] <= wdata_m;
    end
    assign ident_o[d] = pend_q & en_q & route_q[d];
  end

  assign pend_o  = pend_q;
  assign en_o    = en_q;
  assign route_o = route_q;

  logic [WORD_W-1:0] route_or;
  always_comb begin
    route_or = '0;
    for (int d = 0; d < N_DST; d++) route_or |= route_q[d];
  end

  p_src_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_m) |=> ((pend_q & $past(src_m)) == $past(src_m)));

  p_ack_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_we_i |=> ((pend_q & $past(wdata_m & ~src_m)) == '0));

  p_en_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_i |=> ((en_q & $past(wdata_i)) == '0));

  p_en_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_set_i |=> ((en_q & $past(wdata_m)) == $past(wdata_m)));

  p_pad_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q | en_q | route_or) & ~VALID) == '0);
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC  = 86,
  parameter int unsigned N_DST  = 9,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [N_DST-1:0]  dst_o
);
  localparam int unsigned N_BANK = (N_SRC + WORD_W - 1) / WORD_W;
  localparam int unsigned SRC_W  = N_BANK * WORD_W;

  logic                            wr;
  logic [SRC_W-1:0]                src_pad;
  logic [N_BANK-1:0]               pend_hit, en_hit, en_clr_hit, en_set_hit;
  logic [N_BANK-1:0][N_DST-1:0]    route_hit, ident_hit;
  logic [N_BANK-1:0][WORD_W-1:0]   pend, en;
  logic [N_BANK-1:0][N_DST-1:0][WORD_W-1:0] route, ident;

  assign wr = req_i & we_i;

  always_comb begin
    src_pad = '0;
    src_pad[N_SRC-1:0] = src_i;
  end

  irq_route_decode #(
    .N_BANK (N_BANK),
    .N_DST  (N_DST),
    .ADDR_W (ADDR_W)
  ) u_decode (
    .addr_i       (addr_i),
    .pend_hit_o   (pend_hit),
    .en_hit_o     (en_hit),
    .en_clr_hit_o (en_clr_hit),
    .en_set_hit_o (en_set_hit),
    .route_hit_o  (route_hit),
    .ident_hit_o  (ident_hit)
  );

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    irq_route_bank #(
      .N_DST (N_DST),
      .VALID (bank_mask(N_SRC, b))
    ) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_pad[b*WORD_W +: WORD_W]),
      .wdata_i    (wdata_i),
      .pend_we_i  (wr & pend_hit[b]),
      .en_we_i    (wr & en_hit[b]),
      .en_clr_i   (wr & en_clr_hit[b]),
      .en_set_i   (wr & en_set_hit[b]),
      .route_we_i ({N_DST{wr}} & route_hit[b]),
      .pend_o     (pend[b]),
      .en_o       (en[b]),
      .route_o    (route[b]),
      .ident_o    (ident[b])
    );
  end

  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    logic [WORD_W-1:0] any_d;
    always_comb begin
      any_d = '0;
      for (int b = 0; b < N_BANK; b++) any_d |= ident[b][d];
    end
    assign dst_o[d] = |any_d;
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < N_BANK; b++) begin
      if (pend_hit[b]) rdata_o |= pend[b];
      if (en_hit[b] | en_clr_hit[b] | en_set_hit[b]) rdata_o |= en[b];
      for (int d = 0; d < N_DST; d++) begin
        if (route_hit[b][d]) rdata_o |= route[b][d];
        if (ident_hit[b][d]) rdata_o |= ident[b][d];
      end
    end
  end

  p_dec_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pend_hit, en_hit, en_clr_hit, en_set_hit, route_hit, ident_hit}));

  p_dst_needs_pend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dst_o) |-> (|pend));

  p_dst_needs_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dst_o) |-> (|en));
endmodule

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC = 86;
  localparam int N_DST = 9;
  localparam int N_VEC = 22;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N_SRC-1:0]  src = '0;
  logic              req = 1'b0, we = 1'b0;
  logic [9:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [N_DST-1:0]  dst;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .dst_o(dst)
  );

  // {is_read, addr, data_or_expected}
  localparam logic [42:0] VEC [N_VEC] = '{
    {1'b0, 10'h060, 32'h0000_00F0},  // R6 set alias
    {1'b1, 10'h048, 32'h0000_00F0},
    {1'b0, 10'h054, 32'h0000_0030},  // R5 clear alias
    {1'b1, 10'h048, 32'h0000_00C0},
    {1'b0, 10'h048, 32'hA5A5_A5A5},  // R4 direct write
    {1'b1, 10'h048, 32'hA5A5_A5A5},
    {1'b1, 10'h054, 32'hA5A5_A5A5},  // R5 alias reads enable
    {1'b1, 10'h064, 32'h0000_0000},  // R6 bank1 untouched
    {1'b0, 10'h050, 32'hFFFF_FFFF},  // R10 pad bits
    {1'b1, 10'h050, 32'h003F_FFFF},
    {1'b0, 10'h098, 32'h1234_5678},  // R7 bank0 dst8
    {1'b1, 10'h098, 32'h1234_5678},
    {1'b0, 10'h0C4, 32'hFFFF_FFFF},  // R10 bank2 dst1 route
    {1'b1, 10'h0C4, 32'h003F_FFFF},
    {1'b0, 10'h200, 32'hFFFF_FFFF},  // R11 unmapped
    {1'b1, 10'h200, 32'h0000_0000},
    {1'b1, 10'h040, 32'h0000_0000},  // R11 gap
    {1'b0, 10'h0E4, 32'hFFFF_FFFF},  // R8 ident read-only
    {1'b1, 10'h0E4, 32'h0000_0000},
    {1'b0, 10'h05C, 32'hFFFF_FFFF},  // R5 whole-bank disable
    {1'b1, 10'h050, 32'h0000_0000},
    {1'b1, 10'h0C4, 32'h003F_FFFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [9:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic pulse(input int s);
    @(negedge clk);
    src[s] = 1'b1;
    @(negedge clk);
    src[s] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    // R1 reset state
    check("R1 dst in reset", 32'(dst), 32'h0);
    check("R1 pend0 in reset", rdata, 32'h0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    rd("R1 pend1", 10'h034, 32'h0);
    rd("R1 en2", 10'h050, 32'h0);
    rd("R1 route", 10'h078, 32'h0);

    for (int i = 0; i < N_VEC; i++) begin
      if (VEC[i][42]) rd("R4-R11 table", VEC[i][41:32], VEC[i][31:0]);
      else wr(VEC[i][41:32], VEC[i][31:0]);
    end
    wr(10'h048, 32'h0);
    wr(10'h098, 32'h0);
    wr(10'h0C4, 32'h0);

    // R2 capture and hold after the source falls
    pulse(5);
    pulse(40);
    rd("R2 bank0 hold", 10'h030, 32'h0000_0020);
    rd("R2 bank1 bit8", 10'h034, 32'h0000_0100);

    // R3 acknowledge
    wr(10'h034, 32'h0000_0000);
    rd("R3 zero write keeps", 10'h034, 32'h0000_0100);
    wr(10'h034, 32'h0000_0100);
    rd("R3 one write clears", 10'h034, 32'h0);

    // R2 set wins over same-cycle acknowledge
    wr(10'h030, 32'h0000_0020);
    rd("R3 bank0 cleared", 10'h030, 32'h0);
    @(negedge clk);
    src[5] = 1'b1; req = 1'b1; we = 1'b1; addr = 10'h030; wdata = 32'h0000_0020;
    @(negedge clk);
    src[5] = 1'b0; req = 1'b0; we = 1'b0;
    rd("R2 set wins", 10'h030, 32'h0000_0020);

    // R8/R9 routing bank0 source 5 to destination 3
    wr(10'h084, 32'h0000_0020);
    rd("R7 route dst3", 10'h084, 32'h0000_0020);
    check("R9 dst idle without enable", 32'(dst), 32'h0);
    wr(10'h060, 32'h0000_0020);
    rd("R8 ident dst3", 10'h0F0, 32'h0000_0020);
    rd("R8 ident dst2", 10'h0EC, 32'h0);
    check("R9 dst3 raised", 32'(dst), 32'h0000_0008);
    wr(10'h054, 32'h0000_0020);
    check("R5 clear alias drops dst", 32'(dst), 32'h0);
    wr(10'h060, 32'h0000_0020);
    check("R6 set alias raises dst", 32'(dst), 32'h0000_0008);
    wr(10'h030, 32'h0000_0020);
    check("R3 ack drops dst", 32'(dst), 32'h0);

    // top source 85 to destination 8 in bank 2
    pulse(85);
    wr(10'h068, 32'h0020_0000);
    wr(10'h0E0, 32'hFFFF_FFFF);
    rd("R10 route pad", 10'h0E0, 32'h003F_FFFF);
    rd("R8 ident bank2 dst8", 10'h14C, 32'h0020_0000);
    check("R9 dst8 raised", 32'(dst), 32'h0000_0100);
    wr(10'h0E0, 32'h0);
    check("R9 unroute drops dst8", 32'(dst), 32'h0);

    // R1 reset mid-run
    wr(10'h0E0, 32'h0020_0000);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 dst cleared", 32'(dst), 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    rd("R1 pend2 cleared", 10'h038, 32'h0);
    rd("R1 en2 cleared", 10'h068, 32'h0);
    rd("R1 route cleared", 10'h0E0, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule